// File: doc/BRIEF.md
# USB Host Endpoint List Scheduler

This block picks, inside each USB frame, which endpoint-descriptor list the host controller works on next: the periodic list, the control list or the bulk list. A start-of-frame strobe opens each frame. At that strobe the block samples two enable bits into frame-local copies: periodic service on or off, and isochronous descriptors allowed or not. Every decision within the frame uses those copies, so a change software makes to the enables mid-frame only counts from the next frame.

Periodic work comes first in a frame. The isochronous copy is checked whenever the descriptor under service is flagged isochronous. If that copy is clear, periodic service for the rest of the frame is abandoned and the block moves to the control and bulk lists. Between control and bulk, a 2-bit ratio field lets a programmable number of completed control descriptors (one to four) go by before one bulk descriptor is served.

The output is a registered one-hot grant. It stays put until the descriptor engine signals completion, until an isochronous abort, or until a new frame begins.

Top module: `usb_list_sched`

## Requirements
- R1: After reset the grant is idle (all zero) and both frame copies of the enables are clear. No periodic grant appears before the first start-of-frame, even with the periodic enable set and the periodic list non-empty.
- R2: The grant is one-hot or zero. Bit 0 means periodic, bit 1 means control, bit 2 means bulk.
- R3: A non-idle grant stays unchanged until a cycle with descriptor done, start-of-frame, or an isochronous abort (R6).
- R4: In a frame whose periodic copy is set, periodic service is granted while the periodic list is non-empty, ahead of control and bulk.
- R5: The periodic enable is sampled only at start-of-frame. Clearing it mid-frame does not stop the current frame's periodic service, but it removes periodic service from the next frame onward.
- R6: While periodic is granted, an isochronous flag combined with a clear isochronous copy ends periodic service. On the next clock the grant moves to control, bulk or idle, and periodic is not granted again until the next start-of-frame.
- R7: The isochronous enable is sampled only at start-of-frame. A mid-frame change does not alter handling of isochronous descriptors in the current frame.
- R8: With both control and bulk non-empty, ratio field value N (00 to 11) lets N+1 control descriptors complete, and the next grant after that is bulk. Only completed control grants count toward the ratio.
- R9: Completing a bulk descriptor clears the ratio count. Bulk is granted whenever control is empty. Control is granted past its quota when bulk is empty.
- R10: With the control and bulk lists both empty and no periodic service due, the grant is idle.
- R11: A start-of-frame returns the grant to idle on that clock and restarts periodic service. A descriptor done in the same cycle is still counted toward the ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame strobe, one cycle |
| per_busy | input | 1 | Periodic list is non-empty |
| ctl_busy | input | 1 | Control list is non-empty |
| blk_busy | input | 1 | Bulk list is non-empty |
| desc_done | input | 1 | Descriptor under current grant finished (one-cycle pulse) |
| cur_is_iso | input | 1 | Current periodic descriptor is isochronous |
| cfg_iso_en | input | 1 | Isochronous enable, sampled at start-of-frame |
| cfg_per_en | input | 1 | Periodic enable, sampled at start-of-frame |
| cfg_ratio | input | 2 | Control-to-bulk ratio, value N gives (N+1):1 |
| grant | output | 3 | One-hot grant: bit0 periodic, bit1 control, bit2 bulk |

## Verification
The completion of a control descriptor and a start-of-frame can land on the same clock. The frame restart must then idle the grant, while the completion must still advance the ratio count. The bench forces this directly: it raises both strobes together with ratio 1:1 and checks that the grant goes idle and then moves to bulk, not control. Random traffic with frequent strobes and completions also lands the two together many times, and a bench model compares the grant every cycle.

// File: rtl/usb_sched_pkg.sv
package usb_sched_pkg;

    typedef enum logic [2:0] {
        GR_NONE = 3'b000,
        GR_PER  = 3'b001,
        GR_CTL  = 3'b010,
        GR_BLK  = 3'b100
    } grant_e;

    typedef struct packed {
        logic per;
        logic ctl;
        logic blk;
    } list_busy_t;

    // Priority pick: periodic when allowed, then control within quota
    // (or when bulk has nothing), then bulk, else idle.
    function automatic grant_e pick_list(input logic per_ok,
                                         input list_busy_t busy,
                                         input logic quota_ok);
        grant_e g;
        if (per_ok)
            g = GR_PER;
        else if (busy.ctl && (quota_ok || !busy.blk))
            g = GR_CTL;
        else if (busy.blk)
            g = GR_BLK;
        else
            g = GR_NONE;
        return g;
    endfunction

endpackage

// File: rtl/usb_sched_frame.sv
module usb_sched_frame (
    input  logic clk,
    input  logic rst,
    input  logic sof,
    input  logic cfg_per_en,
    input  logic cfg_iso_en,
    input  logic leave_periodic,
    output logic per_sh,
    output logic iso_sh,
    output logic in_periodic
);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_sh      <= 1'b0;
            iso_sh      <= 1'b0;
            in_periodic <= 1'b0;
        end else if (sof) begin
            per_sh      <= cfg_per_en;
            iso_sh      <= cfg_iso_en;
            in_periodic <= 1'b1;
        end else if (leave_periodic) begin
            in_periodic <= 1'b0;
        end
    end

endmodule

// File: rtl/usb_sched_ratio.sv
module usb_sched_ratio #(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       done_ctl,
    input  logic       done_blk,
    input  logic [1:0] ratio,
    output logic       quota_ok
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam int               PAD_W   = CNT_W - 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (done_blk)
            cnt_d = '0;
        else if (done_ctl && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    // Count of completed control grants still within the programmed quota.
    assign quota_ok = (cnt_d <= {{PAD_W{1'b0}}, ratio});

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/usb_sched_grant_reg.sv
module usb_sched_grant_reg
    import usb_sched_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sof,
    input  logic   advance,
    input  grant_e next_grant,
    output grant_e grant_q
);

    always_ff @(posedge clk) begin
        if (rst)
            grant_q <= GR_NONE;
        else if (sof)
            grant_q <= GR_NONE;
        else if (advance)
            grant_q <= next_grant;
    end

endmodule

// File: rtl/usb_list_sched.sv
module usb_list_sched
    import usb_sched_pkg::*;
#(
    parameter int CNT_W = 3  // must hold at least the largest quota (4)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sof,
    input  logic       per_busy,
    input  logic       ctl_busy,
    input  logic       blk_busy,
    input  logic       desc_done,
    input  logic       cur_is_iso,
    input  logic       cfg_iso_en,
    input  logic       cfg_per_en,
    input  logic [1:0] cfg_ratio,
    output logic [2:0] grant
);

    grant_e     grant_q;
    grant_e     next_grant;
    list_busy_t busy;
    logic       per_sh;
    logic       iso_sh;
    logic       in_periodic;
    logic       iso_abort;
    logic       advance;
    logic       per_ok;
    logic       quota_ok;
    logic       leave_periodic;
    logic       done_ctl;
    logic       done_blk;

    assign busy = '{per: per_busy, ctl: ctl_busy, blk: blk_busy};

    assign iso_abort = (grant_q == GR_PER) && cur_is_iso && !iso_sh;
    assign advance   = (grant_q == GR_NONE) || desc_done || iso_abort;
    assign done_ctl  = desc_done && (grant_q == GR_CTL);
    assign done_blk  = desc_done && (grant_q == GR_BLK);
    assign per_ok    = in_periodic && per_sh && busy.per && !iso_abort;

    assign next_grant = pick_list(per_ok, busy, quota_ok);

    assign leave_periodic = iso_abort ||
        (advance && (next_grant == GR_CTL || next_grant == GR_BLK));

    usb_sched_frame u_frame (
        .clk            (clk),
        .rst            (rst),
        .sof            (sof),
        .cfg_per_en     (cfg_per_en),
        .cfg_iso_en     (cfg_iso_en),
        .leave_periodic (leave_periodic),
        .per_sh         (per_sh),
        .iso_sh         (iso_sh),
        .in_periodic    (in_periodic)
    );

    usb_sched_ratio #(.CNT_W(CNT_W)) u_ratio (
        .clk      (clk),
        .rst      (rst),
        .done_ctl (done_ctl),
        .done_blk (done_blk),
        .ratio    (cfg_ratio),
        .quota_ok (quota_ok)
    );

    usb_sched_grant_reg u_grant (
        .clk        (clk),
        .rst        (rst),
        .sof        (sof),
        .advance    (advance),
        .next_grant (next_grant),
        .grant_q    (grant_q)
    );

    assign grant = grant_q;

endmodule

// File: rtl/usb_list_sched_chk.sv
module usb_list_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic       sof,
    input logic       per_busy,
    input logic       ctl_busy,
    input logic       blk_busy,
    input logic       desc_done,
    input logic       cur_is_iso,
    input logic       iso_sh,
    input logic [2:0] grant
);

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (grant != 3'b000 && !desc_done && !sof && !(grant[0] && cur_is_iso))
        |=> $stable(grant));

    p_per_busy_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(grant[0]) |-> $past(per_busy));

    p_iso_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (grant[0] && cur_is_iso && !iso_sh && !sof) |=> !grant[0]);

    p_ctl_busy_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(grant[1]) |-> $past(ctl_busy));

    p_blk_busy_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(grant[2]) |-> $past(blk_busy));

    p_sof_idle_r11: assert property (@(posedge clk) disable iff (rst)
        sof |=> (grant == 3'b000));

endmodule

bind usb_list_sched usb_list_sched_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sof        (sof),
    .per_busy   (per_busy),
    .ctl_busy   (ctl_busy),
    .blk_busy   (blk_busy),
    .desc_done  (desc_done),
    .cur_is_iso (cur_is_iso),
    .iso_sh     (iso_sh),
    .grant      (grant)
);

// File: tb/usb_list_sched_bench.sv
module usb_list_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] G0 = 3'b000, GP = 3'b001, GC = 3'b010, GB = 3'b100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sof = 1'b0, per_busy = 1'b0, ctl_busy = 1'b0, blk_busy = 1'b0;
    logic       desc_done = 1'b0, cur_is_iso = 1'b0;
    logic       cfg_iso_en = 1'b0, cfg_per_en = 1'b0;
    logic [1:0] cfg_ratio = 2'b00;
    logic [2:0] grant;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference state built from the requirements.
    logic [2:0] m_g = G0;
    logic       m_per_sh = 1'b0, m_iso_sh = 1'b0, m_inper = 1'b0;
    int         m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_list_sched u_usb_list_sched (
        .clk(clk), .rst(rst), .sof(sof), .per_busy(per_busy),
        .ctl_busy(ctl_busy), .blk_busy(blk_busy), .desc_done(desc_done),
        .cur_is_iso(cur_is_iso), .cfg_iso_en(cfg_iso_en),
        .cfg_per_en(cfg_per_en), .cfg_ratio(cfg_ratio), .grant(grant)
    );

    function automatic logic [2:0] exp_pick(input logic per_ok, input int cnt);
        if (per_ok) return GP;
        if (ctl_busy && (cnt <= int'(cfg_ratio) || !blk_busy)) return GC;
        if (blk_busy) return GB;
        return G0;
    endfunction

    task automatic model_step();
        logic abort, adv, pok;
        int cnt_n;
        logic [2:0] nxt;
        if (rst) begin
            m_g = G0; m_per_sh = 0; m_iso_sh = 0; m_inper = 0; m_cnt = 0;
            return;
        end
        abort = (m_g == GP) && cur_is_iso && !m_iso_sh;
        adv   = (m_g == G0) || desc_done || abort;
        cnt_n = m_cnt;
        if (desc_done && m_g == GB) cnt_n = 0;
        else if (desc_done && m_g == GC && m_cnt < 7) cnt_n = m_cnt + 1;
        pok = m_inper && m_per_sh && per_busy && !abort;
        nxt = exp_pick(pok, cnt_n);
        if (sof) begin
            m_per_sh = cfg_per_en; m_iso_sh = cfg_iso_en; m_inper = 1; m_g = G0;
        end else begin
            if (abort || (adv && (nxt == GC || nxt == GB))) m_inper = 0;
            if (adv) m_g = nxt;
        end
        m_cnt = cnt_n;
    endtask

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: grant=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 R3 model", grant, m_g);
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
    endtask

    task automatic pulse_done();
        desc_done = 1'b1; tick(); desc_done = 1'b0;
    endtask

    task automatic pulse_sof();
        sof = 1'b1; tick(); sof = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: expired, got=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        tick(); tick();
        chk("R1 reset idle", grant, G0);
        rst = 1'b0;
        // R1: no periodic before first frame strobe
        cfg_per_en = 1; per_busy = 1;
        tick(); tick(); tick();
        chk("R1 no periodic before sof", grant, G0);
        // R4: periodic wins over control
        ctl_busy = 1;
        pulse_sof();
        chk("R11 idle at sof", grant, G0);
        tick();
        chk("R4 periodic first", grant, GP);
        // R3: hold without done
        tick(); tick();
        chk("R3 hold", grant, GP);
        // R5: mid-frame clear keeps this frame
        cfg_per_en = 0;
        pulse_done();
        chk("R5 mid-frame clear ignored", grant, GP);
        pulse_sof(); tick();
        chk("R5 next frame no periodic", grant, GC);
        // R6: iso abort
        cfg_per_en = 1; cfg_iso_en = 0;
        pulse_sof(); tick();
        chk("R6 periodic before iso", grant, GP);
        cur_is_iso = 1; tick(); cur_is_iso = 0;
        chk("R6 abort to control", grant, GC);
        pulse_done();
        chk("R6 no periodic rest of frame", grant, GC);
        // R7: iso enable sampled at frame start
        cfg_iso_en = 1;
        pulse_sof(); tick();
        cur_is_iso = 1; tick();
        chk("R7 iso allowed", grant, GP);
        cfg_iso_en = 0; tick();
        chk("R7 mid-frame iso clear ignored", grant, GP);
        cur_is_iso = 0;
        // R8: ratio 3:1
        do_reset();
        per_busy = 0; cfg_per_en = 0; ctl_busy = 1; blk_busy = 1; cfg_ratio = 2'b10;
        tick();
        chk("R8 first control", grant, GC);
        pulse_done(); chk("R8 second control", grant, GC);
        pulse_done(); chk("R8 third control", grant, GC);
        pulse_done(); chk("R8 bulk after three", grant, GB);
        pulse_done(); chk("R9 count cleared by bulk", grant, GC);
        // R8: ratio 1:1
        do_reset();
        cfg_ratio = 2'b00; tick();
        chk("R8 1:1 control", grant, GC);
        pulse_done(); chk("R8 1:1 bulk", grant, GB);
        pulse_done(); chk("R9 control after bulk", grant, GC);
        // R9: control empty gives bulk
        ctl_busy = 0;
        pulse_done(); chk("R9 bulk when control empty", grant, GB);
        // R10: both empty idle
        blk_busy = 0;
        pulse_done(); chk("R10 idle when empty", grant, G0);
        tick(); chk("R10 stays idle", grant, G0);
        // R11: sof and done together
        do_reset();
        ctl_busy = 1; blk_busy = 1; cfg_ratio = 2'b00; tick();
        chk("R11 setup control", grant, GC);
        sof = 1; desc_done = 1; tick(); sof = 0; desc_done = 0;
        chk("R11 idle on coincident sof", grant, G0);
        tick();
        chk("R11 done counted at sof", grant, GB);
        // Random traffic against the model (R2 R3 R4 R6 R8 R9)
        for (int i = 0; i < 3000; i++) begin
            sof        = ($urandom % 40) == 0;
            desc_done  = (grant != G0) && (($urandom % 3) == 0);
            cur_is_iso = ($urandom % 4) == 0;
            if (($urandom % 8) == 0) per_busy = ~per_busy;
            if (($urandom % 8) == 0) ctl_busy = ~ctl_busy;
            if (($urandom % 8) == 0) blk_busy = ~blk_busy;
            if (($urandom % 50) == 0) cfg_per_en = ~cfg_per_en;
            if (($urandom % 50) == 0) cfg_iso_en = ~cfg_iso_en;
            if (($urandom % 60) == 0) cfg_ratio = 2'($urandom);
            tick();
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule